// File: doc/BRIEF.md
# Presettable Up/Down Counter Slice

A small synchronous binary counter that can count up or down, load a preset word, hold its value, or be cleared at once with no clock edge. It is meant as a building block. Its active-low terminal-count output goes low while the count is all ones. That output can enable a more significant slice, so several slices make a wider counter. It can also be fed back into the synchronous load, so that the slice wraps to a chosen start value or stops short of its full range.

The clear input works asynchronously. The enable and load inputs are active-low. When the slice is enabled, the count moves modulo 2^WIDTH. The terminal-count output is decoded combinationally from the registered count, so a neighbour slice sees it in the same cycle. The count output comes straight from flops.

Top module: `updn_count_slice`

## Requirements
- R1: While `clear` is 1 the count is all zeros. It goes there as soon as `clear` rises, with no clock edge needed.
- R2: While `enable_n` is 1 and `clear` is 0, a clock edge leaves the count unchanged. This holds whatever `load_n`, `count_up` and `preset` are.
- R3: With `enable_n` 0 and `load_n` 0, the clock edge copies `preset` into the count.
- R4: With `enable_n` 0, `load_n` 1 and `count_up` 1, each edge adds one modulo 2^WIDTH, so all ones goes to zero.
- R5: With `enable_n` 0, `load_n` 1 and `count_up` 0, each edge subtracts one modulo 2^WIDTH, so zero goes to all ones.
- R6: `term_n` is 0 exactly while the count is all ones and 1 otherwise, in the same cycle as that count.
- R7: `clear` overrides the enable and load inputs. It zeroes the count even while `enable_n` is 1 and `load_n` is 0.
- R8: When the slice is enabled, a low `load_n` takes precedence over counting in either direction.
- R9: Take two slices that share clock and clear, with the low slice counting up and its `term_n` driving the high slice's `enable_n`. Together they form a binary counter of 2·WIDTH bits that steps by one every clock.
- R10: With `term_n` wired to `load_n`, `preset` = 0110 and counting up, the sequence goes from 1111 to 0110 instead of 0000.
- R11: With a decode of count = 1100 driving `load_n` low, `preset` = 0000 and counting up, the sequence runs 0000 to 1100 and then returns to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clear | input | 1 | Asynchronous clear of the count, active high |
| count_up | input | 1 | 1 = count upward, 0 = count downward |
| load_n | input | 1 | Active-low synchronous load of `preset` |
| enable_n | input | 1 | Active-low enable; high freezes the count |
| preset | input | WIDTH | Value taken on a load |
| count | output | WIDTH | Registered count |
| term_n | output | 1 | Active-low flag, low while count is all ones |

## Verification
The bench builds every slice at the default WIDTH of 4. At that width each slice reaches its terminal count within 16 cycles, so wraps in both directions come up many times. The full 256-state cascade of two slices fits in a few hundred cycles after a clear. The restricted-range wirings with the 0110 and 1100 constants match the 4-bit requirements exactly. One behavioural model per instance is stepped alongside, and it covers clear-over-disable and load-over-count as well as the loops.

// File: rtl/updn_count_pkg.sv
package updn_count_pkg;

  // Action chosen for the next clock edge
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_INC  = 2'd2,
    ACT_DEC  = 2'd3
  } slice_act_e;

endpackage

// File: rtl/updn_count_ctl.sv
module updn_count_ctl
  import updn_count_pkg::*;
(
  input  logic       enable_n,
  input  logic       load_n,
  input  logic       count_up,
  output slice_act_e act
);

  // Precedence: disable, then load, then direction
  always_comb begin
    if (enable_n)      act = ACT_HOLD;
    else if (!load_n)  act = ACT_LOAD;
    else if (count_up) act = ACT_INC;
    else               act = ACT_DEC;
  end

endmodule

// File: rtl/updn_count_next.sv
module updn_count_next
  import updn_count_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  slice_act_e       act,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_comb begin
    case (act)
      ACT_LOAD: nxt = preset;
      ACT_INC:  nxt = cur + STEP;
      ACT_DEC:  nxt = cur - STEP;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/updn_count_reg.sv
module updn_count_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or posedge clear) begin
    if (clear) q <= '0;
    else       q <= d;
  end

endmodule

// File: rtl/updn_count_term.sv
module updn_count_term #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] value,
  output logic             term_n
);

  // Ripple AND chain over the count bits
  logic [WIDTH:0] chain;
  assign chain[0] = 1'b1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_and
    assign chain[b+1] = chain[b] & value[b];
  end

  assign term_n = ~chain[WIDTH];

endmodule

// File: rtl/updn_count_slice.sv
module updn_count_slice
  import updn_count_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             count_up,
  input  logic             load_n,
  input  logic             enable_n,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count,
  output logic             term_n
);

  slice_act_e       act;
  logic [WIDTH-1:0] nxt;

  updn_count_ctl i_ctl (
    .enable_n (enable_n),
    .load_n   (load_n),
    .count_up (count_up),
    .act      (act)
  );

  updn_count_next #(.WIDTH(WIDTH)) i_next (
    .act    (act),
    .cur    (count),
    .preset (preset),
    .nxt    (nxt)
  );

  updn_count_reg #(.WIDTH(WIDTH)) i_reg (
    .clk   (clk),
    .clear (clear),
    .d     (nxt),
    .q     (count)
  );

  updn_count_term #(.WIDTH(WIDTH)) i_term (
    .value  (count),
    .term_n (term_n)
  );

endmodule

// File: rtl/updn_count_slice_chk.sv
module updn_count_slice_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clear,
  input logic             count_up,
  input logic             load_n,
  input logic             enable_n,
  input logic [WIDTH-1:0] preset,
  input logic [WIDTH-1:0] count,
  input logic             term_n
);

  AST_CLEAR_ZERO: assert property (@(posedge clk) clear |-> count == '0)
    else $error("clear did not zero count"); // R1

  AST_CLEAR_OVERRIDES: assert property (@(posedge clk) (clear && (enable_n || !load_n)) |-> count == '0)
    else $error("clear lost to enable or load"); // R7

  AST_HOLD: assert property (@(posedge clk) disable iff (clear) enable_n |=> count == $past(count))
    else $error("count moved while disabled"); // R2

  AST_LOAD: assert property (@(posedge clk) disable iff (clear) (!enable_n && !load_n) |=> count == $past(preset))
    else $error("load not taken"); // R3

  AST_INC: assert property (@(posedge clk) disable iff (clear) (!enable_n && load_n && count_up) |=> count == $past(count) + 1'b1)
    else $error("bad increment"); // R4

  AST_DEC: assert property (@(posedge clk) disable iff (clear) (!enable_n && load_n && !count_up) |=> count == $past(count) - 1'b1)
    else $error("bad decrement"); // R5

  AST_TERM_LOW: assert property (@(posedge clk) disable iff (clear) !term_n |-> $countones(count) == WIDTH)
    else $error("terminal flag without all ones"); // R6

  AST_TERM_HIGH: assert property (@(posedge clk) disable iff (clear) ($countones(count) != WIDTH) |-> term_n)
    else $error("terminal flag missing or spurious"); // R6

endmodule

bind updn_count_slice updn_count_slice_chk #(.WIDTH(WIDTH)) i_chk (
  .clk      (clk),
  .clear    (clear),
  .count_up (count_up),
  .load_n   (load_n),
  .enable_n (enable_n),
  .preset   (preset),
  .count    (count),
  .term_n   (term_n)
);

// File: tb/test_updn_count_slice.sv
module test_updn_count_slice;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       clear = 1'b1;
  logic       count_up = 1'b1;
  logic       load_n = 1'b1;
  logic       enable_n = 1'b1;
  logic [3:0] preset = 4'd0;
  logic [3:0] count;
  logic       term_n;

  // cascade pair, wrap-to-6 slice, modulo-13 slice
  logic [3:0] lo_q, hi_q, wr_q, md_q;
  logic       lo_t, hi_t, wr_t, md_t, md_ld_n;

  int total = 0;
  int bad   = 0;
  int m_main = 0, m_casc = 0, m_wrap = 0, m_mod = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  updn_count_slice i_updn_count_slice (
    .clk(clk), .clear(clear), .count_up(count_up), .load_n(load_n),
    .enable_n(enable_n), .preset(preset), .count(count), .term_n(term_n));

  updn_count_slice i_lo (
    .clk(clk), .clear(clear), .count_up(1'b1), .load_n(1'b1),
    .enable_n(1'b0), .preset(4'd0), .count(lo_q), .term_n(lo_t));

  updn_count_slice i_hi (
    .clk(clk), .clear(clear), .count_up(1'b1), .load_n(1'b1),
    .enable_n(lo_t), .preset(4'd0), .count(hi_q), .term_n(hi_t));

  updn_count_slice i_wrap (
    .clk(clk), .clear(clear), .count_up(1'b1), .load_n(wr_t),
    .enable_n(1'b0), .preset(4'b0110), .count(wr_q), .term_n(wr_t));

  assign md_ld_n = ~(md_q == 4'b1100);

  updn_count_slice i_mod (
    .clk(clk), .clear(clear), .count_up(1'b1), .load_n(md_ld_n),
    .enable_n(1'b0), .preset(4'b0000), .count(md_q), .term_n(md_t));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic check_all(input string tag);
    chk(tag, int'(count), m_main);
    chk("R6 term_n", int'(term_n), (m_main == 15) ? 0 : 1);
    chk("R9 cascade", int'({hi_q, lo_q}), m_casc);
    chk("R10 wrap to 0110", int'(wr_q), m_wrap);
    chk("R11 stop at 1100", int'(md_q), m_mod);
  endtask

  // Drive controls, take one edge, step the models, then compare
  task automatic step(input logic u, input logic ldn, input logic enn, input logic [3:0] p);
    string tag;
    count_up = u; load_n = ldn; enable_n = enn; preset = p;
    @(posedge clk);
    if (!enn) begin
      if (!ldn)   m_main = int'(p);
      else if (u) m_main = (m_main + 1) % 16;
      else        m_main = (m_main + 15) % 16;
    end
    m_casc = (m_casc + 1) % 256;
    m_wrap = (m_wrap == 15) ? 6 : m_wrap + 1;
    m_mod  = (m_mod == 12) ? 0 : m_mod + 1;
    if (enn)       tag = "R2 hold";
    else if (!ldn) tag = "R3 R8 load";
    else if (u)    tag = "R4 up";
    else           tag = "R5 down";
    #1;
    check_all(tag);
  endtask

  // Clear raised between edges; checked before any further edge
  task automatic clear_pulse();
    clear = 1'b1;
    #2;
    m_main = 0; m_casc = 0; m_wrap = 0; m_mod = 0;
    check_all("R1 R7 async clear");
    @(posedge clk);
    #1;
    check_all("R1 R7 clear held over edge");
    clear = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    wrap_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset state");
    clear = 1'b0;
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b0, 4'd0);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 1'b0, 4'd0);
    step(1'b1, 1'b0, 1'b0, 4'd9);
    step(1'b1, 1'b0, 1'b1, 4'd3);
    step(1'b0, 1'b1, 1'b1, 4'd0);
    step(1'b0, 1'b0, 1'b0, 4'd15);
    step(1'b1, 1'b1, 1'b0, 4'd0);
    step(1'b0, 1'b0, 1'b0, 4'd0);
    step(1'b0, 1'b1, 1'b0, 4'd0);
    step(1'b1, 1'b0, 1'b0, 4'd7);
    enable_n = 1'b1;
    load_n   = 1'b0;
    preset   = 4'd5;
    clear_pulse();
    for (int i = 0; i < 300; i++)
      step(((i / 37) % 2) == 0, (i % 23) != 5, (i % 11) == 3, 4'(i % 16));
    wrap_up();
  end

endmodule